// File: doc/BRIEF.md
# Indexed Message Buffer Pointer Manager

This block performs the per-subaddress buffer bookkeeping of a MIL-STD-1553 remote terminal once a message ends. It keeps a small descriptor table with one entry per direction and subaddress. Each entry holds a control word, a 10-bit message index count, a primary data pointer and a broadcast data pointer. When the protocol engine reports a finished message, the block chooses the buffer that the message used and advances the index count and the primary pointer as needed. It also sets interrupt-pending bits and drives one interrupt line.

The host loads descriptors through a word-wide table port. It controls the block through three registers: configuration, interrupt enable and interrupt pending. A nonzero index count gives N-message buffering: the primary pointer moves past each good message until the count reaches zero, and then it stays fixed. A count of zero from the start gives single-message buffering. One configuration bit picks how broadcasts are handled. They either go to a separate per-entry broadcast buffer and leave the count alone, or they are treated like ordinary messages and only flagged.

Top module: `msg_buf_ptr_mgr`

## Requirements
- R1: After reset, every descriptor field, the configuration, enable and pending registers all read zero, and irq_o is low.
- R2: A finished message that is error-free and legal, on an entry whose index count is nonzero and that is not routed to the broadcast buffer, decrements the count by one. It also advances the primary pointer by the word count plus 2, modulo 2^16.
- R3: A finished message on an entry whose count is zero changes neither the count nor the primary pointer. When the count steps from 1 to 0, the primary pointer keeps its advanced value and is not reloaded.
- R4: A message flagged illegal changes neither the count nor the primary pointer.
- R5: Pending bit 0 is set when a count steps from 1 to 0, but only when bit 15 of that entry's control word is 1.
- R6: A message flagged with an error sets pending bit 2 and nothing else: descriptors and the other pending bits are unchanged.
- R7: With configuration bit 0 set, a good broadcast message uses the entry's broadcast pointer as its target. It leaves the count and the primary pointer unchanged.
- R8: With configuration bit 0 clear, a broadcast message targets the primary pointer and updates the entry as in R2 and R3. res_bcast_o reports 1 for any broadcast message.
- R9: A broadcast message that is error-free and legal sets pending bit 1 when bit 14 of the entry's control word is 1.
- R10: Writing the pending register clears exactly those pending bits written as 1. Bits written as 0 stay unchanged.
- R11: irq_o is high exactly when some pending bit is set and its enable bit, at the same position in the enable register, is also set.
- R12: One cycle after msg_done_i, res_valid_o pulses high. At the same time res_addr_o shows the target pointer value held before the update.
- R13: An entry is addressed as {tx, subaddress}, for 64 entries. The descriptor field codes are 0 control, 1 index count, 2 primary pointer and 3 broadcast pointer. The register select codes are 0 configuration, 1 enable and 2 pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Descriptor table write strobe |
| desc_ent_i | input | 6 | Descriptor entry {tx, subaddress} |
| desc_fld_i | input | 2 | Descriptor field code |
| desc_wdata_i | input | 16 | Descriptor write data |
| desc_rdata_o | output | 16 | Descriptor read data for the selected entry and field |
| reg_we_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 2 | Host register select |
| reg_wdata_i | input | 16 | Host register write data |
| reg_rdata_o | output | 16 | Host register read data |
| msg_done_i | input | 1 | Message-complete strobe from the protocol engine |
| msg_tx_i | input | 1 | Message direction, 1 for transmit |
| msg_sa_i | input | 5 | Message subaddress or mode code |
| msg_bcast_i | input | 1 | Message was a broadcast |
| msg_err_i | input | 1 | Message ended with an error |
| msg_illegal_i | input | 1 | Command was illegalized |
| msg_wcnt_i | input | 6 | Data word count of the message (1 to 32) |
| res_valid_o | output | 1 | Post-processing result valid pulse |
| res_addr_o | output | 16 | Target buffer address used by the message |
| res_bcast_o | output | 1 | Broadcast flag for the message information word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that no decrement happens on a zero count, an error or an illegal command. They check that pending bits stay set until a host write clears them, that the count-zero pending bit rises only on a real 1-to-0 step of an entry that asks for it, and that the interrupt line never rises without a pending bit. The exact pointer arithmetic, the wrap at the top of the address space, and the choice of target under each broadcast setting can only be shown by the bench's scenarios. The same holds for the enable masking and for descriptors staying untouched after rejected messages. The bench checks these against a model of the table that it keeps itself.

// File: rtl/mbpm_pkg.sv
package mbpm_pkg;
  typedef enum logic [1:0] {FLD_CTRL = 2'd0, FLD_INDEX = 2'd1, FLD_PTRA = 2'd2, FLD_PTRB = 2'd3} desc_fld_e;
  typedef enum logic [1:0] {REG_CFG = 2'd0, REG_IEN = 2'd1, REG_IPND = 2'd2, REG_NONE = 2'd3} host_reg_e;

  localparam int PND_W    = 3;
  localparam int PB_IXEQZ = 0;
  localparam int PB_IBRD  = 1;
  localparam int PB_MERR  = 2;

  localparam int CW_IXEQZ = 15;
  localparam int CW_IBRD  = 14;
  localparam int CFG_SEP  = 0;
endpackage

// File: rtl/mbpm_desc_store.sv
module mbpm_desc_store
  import mbpm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int IW  = 10,
  parameter int EW  = 6,
  localparam int NE = 1 << EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [EW-1:0] host_ent_i,
  input  desc_fld_e     host_fld_i,
  input  logic [AW-1:0] host_wdata_i,
  output logic [AW-1:0] host_rdata_o,
  input  logic [EW-1:0] msg_ent_i,
  output logic [AW-1:0] cur_ctrl_o,
  output logic [IW-1:0] cur_idx_o,
  output logic [AW-1:0] cur_pa_o,
  output logic [AW-1:0] cur_pb_o,
  input  logic          upd_dec_i,
  input  logic          upd_ptr_i,
  input  logic [AW-1:0] new_pa_i
);
  logic [AW-1:0] ctrl_q [NE];
  logic [IW-1:0] idx_q  [NE];
  logic [AW-1:0] pa_q   [NE];
  logic [AW-1:0] pb_q   [NE];

  // message update is written last so it wins a same-entry collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NE; i++) begin
        ctrl_q[i] <= '0;
        idx_q[i]  <= '0;
        pa_q[i]   <= '0;
        pb_q[i]   <= '0;
      end
    end else begin
      if (host_we_i) begin
        case (host_fld_i)
          FLD_CTRL:  ctrl_q[host_ent_i] <= host_wdata_i;
          FLD_INDEX: idx_q[host_ent_i]  <= host_wdata_i[IW-1:0];
          FLD_PTRA:  pa_q[host_ent_i]   <= host_wdata_i;
          default:   pb_q[host_ent_i]   <= host_wdata_i;
        endcase
      end
      if (upd_dec_i) idx_q[msg_ent_i] <= idx_q[msg_ent_i] - IW'(1);
      if (upd_ptr_i) pa_q[msg_ent_i]  <= new_pa_i;
    end
  end

  always_comb begin
    case (host_fld_i)
      FLD_CTRL:  host_rdata_o = ctrl_q[host_ent_i];
      FLD_INDEX: host_rdata_o = {{(AW-IW){1'b0}}, idx_q[host_ent_i]};
      FLD_PTRA:  host_rdata_o = pa_q[host_ent_i];
      default:   host_rdata_o = pb_q[host_ent_i];
    endcase
  end

  assign cur_ctrl_o = ctrl_q[msg_ent_i];
  assign cur_idx_o  = idx_q[msg_ent_i];
  assign cur_pa_o   = pa_q[msg_ent_i];
  assign cur_pb_o   = pb_q[msg_ent_i];
endmodule

// File: rtl/mbpm_post_ctl.sv
module mbpm_post_ctl
  import mbpm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int IW  = 10,
  parameter int WW  = 6,
  parameter int OVH = 2
) (
  input  logic             msg_done_i,
  input  logic             msg_bcast_i,
  input  logic             msg_err_i,
  input  logic             msg_illegal_i,
  input  logic [WW-1:0]    msg_wcnt_i,
  input  logic             sep_en_i,
  input  logic [AW-1:0]    cur_ctrl_i,
  input  logic [IW-1:0]    cur_idx_i,
  input  logic [AW-1:0]    cur_pa_i,
  input  logic [AW-1:0]    cur_pb_i,
  output logic             upd_dec_o,
  output logic             upd_ptr_o,
  output logic [AW-1:0]    new_pa_o,
  output logic [AW-1:0]    target_o,
  output logic [PND_W-1:0] set_pnd_o
);
  logic good, to_bbuf, idx_nz;

  assign good    = msg_done_i & ~msg_err_i & ~msg_illegal_i;
  assign to_bbuf = msg_bcast_i & sep_en_i;
  assign idx_nz  = (cur_idx_i != '0);

  assign upd_dec_o = good & ~to_bbuf & idx_nz;
  assign upd_ptr_o = upd_dec_o;
  assign new_pa_o  = cur_pa_i + AW'(msg_wcnt_i) + AW'(OVH);
  assign target_o  = to_bbuf ? cur_pb_i : cur_pa_i;

  always_comb begin
    set_pnd_o           = '0;
    set_pnd_o[PB_IXEQZ] = upd_dec_o & (cur_idx_i == IW'(1)) & cur_ctrl_i[CW_IXEQZ];
    set_pnd_o[PB_IBRD]  = good & msg_bcast_i & cur_ctrl_i[CW_IBRD];
    set_pnd_o[PB_MERR]  = msg_done_i & msg_err_i;
  end
endmodule

// File: rtl/mbpm_irq_regs.sv
module mbpm_irq_regs
  import mbpm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  host_reg_e        sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [PND_W-1:0] set_i,
  output logic             sep_en_o,
  output logic [PND_W-1:0] pnd_o,
  output logic             irq_o
);
  logic             cfg_q;
  logic [PND_W-1:0] ien_q, pnd_q, clr;

  assign clr = (we_i && sel_i == REG_IPND) ? wdata_i[PND_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= 1'b0;
      ien_q <= '0;
      pnd_q <= '0;
    end else begin
      if (we_i && sel_i == REG_CFG) cfg_q <= wdata_i[CFG_SEP];
      if (we_i && sel_i == REG_IEN) ien_q <= wdata_i[PND_W-1:0];
      pnd_q <= (pnd_q & ~clr) | set_i;  // a new event wins over a clear
    end
  end

  always_comb begin
    case (sel_i)
      REG_CFG:  rdata_o = DW'(cfg_q);
      REG_IEN:  rdata_o = DW'(ien_q);
      REG_IPND: rdata_o = DW'(pnd_q);
      default:  rdata_o = '0;
    endcase
  end

  assign sep_en_o = cfg_q;
  assign pnd_o    = pnd_q;
  assign irq_o    = |(pnd_q & ien_q);
endmodule

// File: rtl/msg_buf_ptr_mgr.sv
module msg_buf_ptr_mgr
  import mbpm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int IW  = 10,
  parameter int SAW = 5,
  parameter int WW  = 6,
  parameter int OVH = 2,
  localparam int EW = SAW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          desc_we_i,
  input  logic [EW-1:0] desc_ent_i,
  input  logic [1:0]    desc_fld_i,
  input  logic [AW-1:0] desc_wdata_i,
  output logic [AW-1:0] desc_rdata_o,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          msg_done_i,
  input  logic          msg_tx_i,
  input  logic [SAW-1:0] msg_sa_i,
  input  logic          msg_bcast_i,
  input  logic          msg_err_i,
  input  logic          msg_illegal_i,
  input  logic [WW-1:0] msg_wcnt_i,
  output logic          res_valid_o,
  output logic [AW-1:0] res_addr_o,
  output logic          res_bcast_o,
  output logic          irq_o
);
  logic [EW-1:0]    msg_ent;
  logic [AW-1:0]    cur_ctrl, cur_pa, cur_pb, new_pa, target;
  logic [IW-1:0]    cur_idx;
  logic             upd_dec, upd_ptr, sep_en;
  logic [PND_W-1:0] set_pnd, pnd_w;

  assign msg_ent = {msg_tx_i, msg_sa_i};

  mbpm_desc_store #(.AW(AW), .IW(IW), .EW(EW)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (desc_we_i),
    .host_ent_i   (desc_ent_i),
    .host_fld_i   (desc_fld_e'(desc_fld_i)),
    .host_wdata_i (desc_wdata_i),
    .host_rdata_o (desc_rdata_o),
    .msg_ent_i    (msg_ent),
    .cur_ctrl_o   (cur_ctrl),
    .cur_idx_o    (cur_idx),
    .cur_pa_o     (cur_pa),
    .cur_pb_o     (cur_pb),
    .upd_dec_i    (upd_dec),
    .upd_ptr_i    (upd_ptr),
    .new_pa_i     (new_pa)
  );

  mbpm_post_ctl #(.AW(AW), .IW(IW), .WW(WW), .OVH(OVH)) u_ctl (
    .msg_done_i    (msg_done_i),
    .msg_bcast_i   (msg_bcast_i),
    .msg_err_i     (msg_err_i),
    .msg_illegal_i (msg_illegal_i),
    .msg_wcnt_i    (msg_wcnt_i),
    .sep_en_i      (sep_en),
    .cur_ctrl_i    (cur_ctrl),
    .cur_idx_i     (cur_idx),
    .cur_pa_i      (cur_pa),
    .cur_pb_i      (cur_pb),
    .upd_dec_o     (upd_dec),
    .upd_ptr_o     (upd_ptr),
    .new_pa_o      (new_pa),
    .target_o      (target),
    .set_pnd_o     (set_pnd)
  );

  mbpm_irq_regs #(.DW(AW)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (host_reg_e'(reg_sel_i)),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .set_i    (set_pnd),
    .sep_en_o (sep_en),
    .pnd_o    (pnd_w),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_addr_o  <= '0;
      res_bcast_o <= 1'b0;
    end else begin
      res_valid_o <= msg_done_i;
      if (msg_done_i) begin
        res_addr_o  <= target;
        res_bcast_o <= msg_bcast_i;
      end
    end
  end
endmodule

// File: rtl/mbpm_checker.sv
module mbpm_checker
  import mbpm_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_done_i,
  input logic             msg_err_i,
  input logic             msg_illegal_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_sel_i,
  input logic [AW-1:0]    reg_wdata_i,
  input logic             upd_dec,
  input logic             upd_ptr,
  input logic [IW-1:0]    cur_idx,
  input logic [AW-1:0]    cur_ctrl,
  input logic [PND_W-1:0] pnd_w,
  input logic             res_valid_o,
  input logic             irq_o
);
  assert_no_dec_at_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_dec || upd_ptr) |-> cur_idx != '0);

  assert_illegal_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_done_i && msg_illegal_i) |-> !upd_dec && !upd_ptr);

  assert_error_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_done_i && msg_err_i) |-> !upd_dec && !upd_ptr);

  assert_ixeqz_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pnd_w[PB_IXEQZ]) |-> $past(upd_dec && cur_idx == IW'(1) && cur_ctrl[CW_IXEQZ]));

  assert_update_needs_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_dec |=> res_valid_o);

  assert_irq_needs_pending_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pnd_w != '0);

  for (genvar b = 0; b < PND_W; b++) begin : g_sticky
    assert_pending_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pnd_w[b] && !(reg_we_i && reg_sel_i == 2'd2 && reg_wdata_i[b])) |=> pnd_w[b]);
  end
endmodule

bind msg_buf_ptr_mgr mbpm_checker #(.AW(AW), .IW(IW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .msg_done_i    (msg_done_i),
  .msg_err_i     (msg_err_i),
  .msg_illegal_i (msg_illegal_i),
  .reg_we_i      (reg_we_i),
  .reg_sel_i     (reg_sel_i),
  .reg_wdata_i   (reg_wdata_i),
  .upd_dec       (upd_dec),
  .upd_ptr       (upd_ptr),
  .cur_idx       (cur_idx),
  .cur_ctrl      (cur_ctrl),
  .pnd_w         (pnd_w),
  .res_valid_o   (res_valid_o),
  .irq_o         (irq_o)
);

// File: tb/msg_buf_ptr_mgr_tb.sv
module msg_buf_ptr_mgr_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        desc_we_i = 1'b0;
  logic [5:0]  desc_ent_i = '0;
  logic [1:0]  desc_fld_i = '0;
  logic [15:0] desc_wdata_i = '0;
  logic [15:0] desc_rdata_o;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        msg_done_i = 1'b0;
  logic        msg_tx_i = 1'b0;
  logic [4:0]  msg_sa_i = '0;
  logic        msg_bcast_i = 1'b0;
  logic        msg_err_i = 1'b0;
  logic        msg_illegal_i = 1'b0;
  logic [5:0]  msg_wcnt_i = '0;
  logic        res_valid_o;
  logic [15:0] res_addr_o;
  logic        res_bcast_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] m_ctrl [64];
  logic [9:0]  m_idx  [64];
  logic [15:0] m_pa   [64];
  logic [15:0] m_pb   [64];
  logic        m_cfg;
  logic [2:0]  m_en, m_pnd;

  always #4 clk_i = ~clk_i;

  msg_buf_ptr_mgr dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dwr(input int ent, input int fld, input logic [15:0] v);
    @(negedge clk_i);
    desc_we_i = 1'b1; desc_ent_i = 6'(ent); desc_fld_i = 2'(fld); desc_wdata_i = v;
    @(negedge clk_i);
    desc_we_i = 1'b0;
    case (fld)
      0: m_ctrl[ent] = v;
      1: m_idx[ent]  = v[9:0];
      2: m_pa[ent]   = v;
      default: m_pb[ent] = v;
    endcase
  endtask

  task automatic drd(input int ent, input int fld, input logic [15:0] exp, input string req);
    desc_ent_i = 6'(ent); desc_fld_i = 2'(fld);
    #1;
    chk(req, 32'(desc_rdata_o), 32'(exp));
  endtask

  task automatic rwr(input int sel, input logic [15:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = 2'(sel); reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    case (sel)
      0: m_cfg = v[0];
      1: m_en  = v[2:0];
      default: m_pnd = m_pnd & ~v[2:0];
    endcase
  endtask

  task automatic rrd(input int sel, input logic [15:0] exp, input string req);
    reg_sel_i = 2'(sel);
    #1;
    chk(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic check_irq(input string req);
    rrd(2, 16'(m_pnd), req);
    chk(req, 32'(irq_o), 32'(|(m_pnd & m_en)));
  endtask

  task automatic send(input int ent, input bit b, input bit e, input bit il, input int wc);
    logic [15:0] tgt;
    bit good, routed;
    string req;
    good   = !e && !il;
    routed = b && m_cfg;
    tgt    = routed ? m_pb[ent] : m_pa[ent];
    if (e) req = "R6";
    else if (il) req = "R4";
    else if (routed) req = "R7";
    else if (b) req = "R8";
    else if (m_idx[ent] == 0) req = "R3";
    else req = "R2";
    @(negedge clk_i);
    msg_done_i = 1'b1; msg_tx_i = ent[5]; msg_sa_i = ent[4:0];
    msg_bcast_i = b; msg_err_i = e; msg_illegal_i = il; msg_wcnt_i = 6'(wc);
    @(negedge clk_i);
    msg_done_i = 1'b0;
    chk("R12 valid", 32'(res_valid_o), 32'd1);
    chk({req, " R12 target"}, 32'(res_addr_o), 32'(tgt));
    chk("R8 bcast flag", 32'(res_bcast_o), 32'(b));
    if (e) m_pnd[2] = 1'b1;
    if (good && b && m_ctrl[ent][14]) m_pnd[1] = 1'b1;
    if (good && !routed && m_idx[ent] != 0) begin
      if (m_idx[ent] == 10'd1 && m_ctrl[ent][15]) m_pnd[0] = 1'b1;
      m_idx[ent] = m_idx[ent] - 10'd1;
      m_pa[ent]  = m_pa[ent] + 16'(wc) + 16'd2;
    end
    drd(ent, 1, 16'(m_idx[ent]), {req, " index"});
    drd(ent, 2, m_pa[ent], {req, " ptrA"});
    check_irq({req, " R5 R9 R11 pending"});
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1553);
    for (int i = 0; i < 64; i++) begin
      m_ctrl[i] = '0; m_idx[i] = '0; m_pa[i] = '0; m_pb[i] = '0;
    end
    m_cfg = 1'b0; m_en = '0; m_pnd = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rrd(0, 16'h0, "R1 cfg");
    rrd(1, 16'h0, "R1 enable");
    rrd(2, 16'h0, "R1 pending");
    chk("R1 irq", 32'(irq_o), 32'd0);
    for (int f = 0; f < 4; f++) drd(37, f, 16'h0, "R1 descriptor");

    // R2/R5/R3: count 2 down to 0, IXEQZ requested
    rwr(1, 16'h7);
    dwr(5, 0, 16'h8000); dwr(5, 1, 16'd2); dwr(5, 2, 16'h0100);
    drd(5, 0, 16'h8000, "R13 ctrl field");
    send(5, 0, 0, 0, 4);
    drd(5, 2, 16'h0106, "R2 advance by wc+2");
    send(5, 0, 0, 0, 32);
    chk("R5 pending bit0", 32'(reg_rdata_o[0]), 32'd1);
    chk("R11 irq", 32'(irq_o), 32'd1);
    drd(5, 2, 16'h0128, "R3 no reload at zero");
    send(5, 0, 0, 0, 7);
    drd(5, 2, 16'h0128, "R3 frozen");
    // R10 write-one-to-clear
    rwr(2, 16'h0);
    check_irq("R10 zero write keeps");
    rwr(2, 16'h1);
    check_irq("R10 clear");
    chk("R10 irq low", 32'(irq_o), 32'd0);

    // R2 wrap, R5 negative (bit15 clear), R13 tx entry
    dwr(40, 1, 16'd1); dwr(40, 2, 16'hFFFE);
    send(40, 0, 0, 0, 1);
    drd(40, 2, 16'h0001, "R2 wrap");

    // R4 illegal, R6 error
    dwr(6, 0, 16'hC000); dwr(6, 1, 16'd3); dwr(6, 2, 16'h0400);
    send(6, 0, 0, 1, 10);
    send(6, 1, 1, 0, 10);
    chk("R6 only bit2", 32'(reg_rdata_o), 32'h4);

    // R7/R9 separated broadcast
    rwr(0, 16'h1);
    dwr(7, 0, 16'h4000); dwr(7, 1, 16'd3); dwr(7, 2, 16'h0200); dwr(7, 3, 16'h0300);
    send(7, 1, 0, 0, 5);
    drd(7, 1, 16'd3, "R7 count kept");
    chk("R9 bit1", 32'(m_pnd[1]), 32'd1);
    // R8 broadcast handled normally
    rwr(0, 16'h0);
    send(7, 1, 0, 0, 5);
    drd(7, 1, 16'd2, "R8 count dec");

    // R11 enable masking, R13 max count
    rwr(1, 16'h0);
    check_irq("R11 masked");
    dwr(63, 1, 16'h03FF);
    drd(63, 1, 16'h03FF, "R13 max count");
    rwr(2, 16'h7);
    rwr(1, 16'h7);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int ent, wc;
      bit b, e, il;
      ent = ($urandom % 8) + (($urandom % 2) * 32);
      if ($urandom % 6 == 0) dwr(ent, 1, 16'($urandom % 4));
      if ($urandom % 10 == 0) dwr(ent, 0, 16'($urandom) & 16'hC000);
      if ($urandom % 12 == 0) dwr(ent, 2, 16'($urandom));
      if ($urandom % 12 == 0) dwr(ent, 3, 16'($urandom));
      if ($urandom % 25 == 0) rwr(0, 16'($urandom % 2));
      if ($urandom % 15 == 0) rwr(2, 16'($urandom % 8));
      if ($urandom % 30 == 0) rwr(1, 16'($urandom % 8));
      b  = ($urandom % 4) == 0;
      e  = ($urandom % 8) == 0;
      il = ($urandom % 8) == 0;
      wc = ($urandom % 32) + 1;
      send(ent, b, e, il, wc);
      @(negedge clk_i);
      chk("R12 single pulse", 32'(res_valid_o), 32'd0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule